// File: doc/BRIEF.md
# Fuse Program Request Checker

This block takes a one-cycle request to blow a single bit in a one-time-programmable fuse store. The request address holds an array index, a row and a column. The index space has a hole at index 1, so the block moves indices 2 and 3 down onto storage arrays 1 and 2. It then runs a fixed sequence of permission checks. If every check passes, it sets the addressed bit. A fuse bit can be set but never cleared.

On the cycle after each request, the block raises a done pulse. It raises an error pulse with it if any check failed, and it presents a code naming the first check that failed. The interrupt logic consumes these pulses. A registered row-read port gives the surrounding logic, and the bench, a view of the stored words.

The storage holds three arrays of 64 rows by 32 bits. One bit of storage array 0 acts as a write lock for the two remapped arrays. A separate key-store lock input protects rows 24 to 31 of array 0. Programming pulse timing is not modelled.

Top module: `fuse_prog_gate`

## Requirements
- R1: The request address carries the column in bits 4:0, the row in bits 10:5 and the array index in bits 12:11. Index 0 selects storage array 0, index 2 selects storage array 1 and index 3 selects storage array 2. The bit written is bit `column` of word `row`, which is linear position row*32+column.
- R2: A request with array index 1 fails with error code 1. This check comes before every other check, so the lock and enable inputs make no difference to it.
- R3: With a valid index and reg_lock high, the request fails with code 2.
- R4: With a valid index, reg_lock low and prog_en low, the request fails with code 3.
- R5: If storage array 0, row 21, column 30 is set, requests to index 2 or 3 that pass R2 to R4 fail with code 4. Requests to index 0 are not affected by this bit.
- R6: With key_wr_lock high, a request to index 0 whose row lies from 24 to 31 inclusive fails with code 5, provided it passes R2 to R4. Rows 23 and 32, and the other arrays, are not affected.
- R7: A request that passes every check sets the target bit and leaves the other bits of that row as they were. err_pulse stays low and err_code is 0.
- R8: done_pulse is high for exactly the one cycle after each request, whether the request passes or fails, and is low otherwise. err_pulse is never high without done_pulse.
- R9: A failed request leaves the storage unchanged.
- R10: After reset, done_pulse, err_pulse, err_code and rd_word are all 0.
- R11: rd_word shows storage word (rd_sel, rd_row) one cycle after it is addressed. An rd_sel value of 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | One-cycle program request strobe |
| req_addr | input | 13 | Request address: array index, row and column |
| reg_lock | input | 1 | Register write lock is active |
| prog_en | input | 1 | Programming enabled by configuration |
| key_wr_lock | input | 1 | Write lock for the key-store rows |
| rd_sel | input | 2 | Storage array selected for reading |
| rd_row | input | 6 | Row selected for reading |
| done_pulse | output | 1 | Request finished, one cycle after the strobe |
| err_pulse | output | 1 | Request rejected, high together with done_pulse |
| err_code | output | 3 | Cause of the rejection, 0 on success |
| rd_word | output | 32 | Registered storage row |

## Verification
The bench probes the order of the checks with requests that break several rules at once. Examples are index 1 with the lock held, and a remapped array whose syndrome lock is set while programming is disabled. A design with the order wrong reports the wrong code. It also probes the edges of the key-store row range at rows 23, 24, 31 and 32, and the fact that the key lock does not apply to remapped arrays. An off-by-one range, or a lock applied to every array, would reject a legal write or accept a protected one. Read-back checks that rejected writes leave storage untouched and that two writes to one row accumulate. A design that wrote on error, or overwrote instead of merging, shows the wrong row value. They also check that index 2 and 3 writes land in storage arrays 1 and 2, which catches a missing or wrong remap.

// File: rtl/fpg_pkg.sv
package fpg_pkg;
  typedef enum logic [2:0] {
    FPG_OK        = 3'd0,
    FPG_BAD_ARRAY = 3'd1,
    FPG_REG_LOCK  = 3'd2,
    FPG_PGM_OFF   = 3'd3,
    FPG_SYN_LOCK  = 3'd4,
    FPG_KEY_LOCK  = 3'd5
  } fpg_err_e;
endpackage

// File: rtl/fpg_addr_decode.sv
module fpg_addr_decode #(
  parameter int COL_W  = 5,
  parameter int ROW_W  = 6,
  parameter int ARR_W  = 2,
  parameter int NSTORE = 3,
  localparam int SEL_W = $clog2(NSTORE + 1),
  localparam int ADDR_W = COL_W + ROW_W + ARR_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              valid,
  output logic              remapped,
  output logic [SEL_W-1:0]  sel,
  output logic [ROW_W-1:0]  row,
  output logic [COL_W-1:0]  col
);
  logic [ARR_W-1:0] arr;

  assign col = addr[COL_W-1:0];
  assign row = addr[COL_W +: ROW_W];
  assign arr = addr[COL_W+ROW_W +: ARR_W];

  // Index 0 is used as is; index 1 is a hole; indices 2..NSTORE move down by one.
  always_comb begin
    valid    = 1'b0;
    remapped = 1'b0;
    sel      = '0;
    if (arr == '0) begin
      valid = 1'b1;
    end else if (32'(arr) >= 2 && 32'(arr) <= NSTORE) begin
      valid    = 1'b1;
      remapped = 1'b1;
      sel      = SEL_W'(32'(arr) - 1);
    end
  end
endmodule

// File: rtl/fpg_perm_check.sv
module fpg_perm_check
  import fpg_pkg::*;
#(
  parameter int ROW_W   = 6,
  parameter int KEY_LO  = 24,
  parameter int KEY_HI  = 31
) (
  input  logic             valid,
  input  logic             remapped,
  input  logic [ROW_W-1:0] row,
  input  logic             reg_lock,
  input  logic             prog_en,
  input  logic             syn_lock,
  input  logic             key_wr_lock,
  output fpg_err_e         code
);
  logic in_key_rows;

  assign in_key_rows = (32'(row) >= KEY_LO) && (32'(row) <= KEY_HI);

  // First failing check wins; order is fixed.
  always_comb begin
    if (!valid)                                code = FPG_BAD_ARRAY;
    else if (reg_lock)                         code = FPG_REG_LOCK;
    else if (!prog_en)                         code = FPG_PGM_OFF;
    else if (remapped && syn_lock)             code = FPG_SYN_LOCK;
    else if (!remapped && key_wr_lock && in_key_rows) code = FPG_KEY_LOCK;
    else                                       code = FPG_OK;
  end
endmodule

// File: rtl/fpg_fuse_store.sv
module fpg_fuse_store #(
  parameter int COL_W   = 5,
  parameter int ROW_W   = 6,
  parameter int NSTORE  = 3,
  parameter int SYN_ROW = 21,
  parameter int SYN_COL = 30,
  localparam int COLS   = 1 << COL_W,
  localparam int ROWS   = 1 << ROW_W,
  localparam int DEPTH  = NSTORE * ROWS,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int SEL_W  = $clog2(NSTORE + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [ROW_W-1:0] wr_row,
  input  logic [COL_W-1:0] wr_col,
  input  logic [SEL_W-1:0] rd_sel,
  input  logic [ROW_W-1:0] rd_row,
  output logic [COLS-1:0]  rd_word,
  output logic             syn_bit
);
  logic [COLS-1:0] mem [DEPTH];
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic             rd_ok;

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  assign wr_idx  = IDX_W'(32'(wr_sel) * ROWS + 32'(wr_row));
  assign rd_idx  = IDX_W'(32'(rd_sel) * ROWS + 32'(rd_row));
  assign rd_ok   = 32'(rd_sel) < NSTORE;
  assign syn_bit = mem[SYN_ROW][SYN_COL];

  // Fuse semantics: a write only ORs one bit into the row.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= mem[wr_idx] | (COLS'(1) << wr_col);
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_word <= '0;
    else if (rd_ok) rd_word <= mem[rd_idx];
    else            rd_word <= '0;
  end
endmodule

// File: rtl/fuse_prog_gate.sv
module fuse_prog_gate
  import fpg_pkg::*;
#(
  parameter int COL_W   = 5,
  parameter int ROW_W   = 6,
  parameter int ARR_W   = 2,
  parameter int NSTORE  = 3,
  parameter int KEY_LO  = 24,
  parameter int KEY_HI  = 31,
  parameter int SYN_ROW = 21,
  parameter int SYN_COL = 30,
  localparam int ADDR_W = COL_W + ROW_W + ARR_W,
  localparam int COLS   = 1 << COL_W,
  localparam int SEL_W  = $clog2(NSTORE + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              reg_lock,
  input  logic              prog_en,
  input  logic              key_wr_lock,
  input  logic [SEL_W-1:0]  rd_sel,
  input  logic [ROW_W-1:0]  rd_row,
  output logic              done_pulse,
  output logic              err_pulse,
  output logic [2:0]        err_code,
  output logic [COLS-1:0]   rd_word
);
  logic             a_valid, a_remap, syn_bit;
  logic [SEL_W-1:0] a_sel;
  logic [ROW_W-1:0] a_row;
  logic [COL_W-1:0] a_col;
  fpg_err_e         code;

  fpg_addr_decode #(.COL_W(COL_W), .ROW_W(ROW_W), .ARR_W(ARR_W), .NSTORE(NSTORE)) u_dec (
    .addr(req_addr), .valid(a_valid), .remapped(a_remap),
    .sel(a_sel), .row(a_row), .col(a_col)
  );

  fpg_perm_check #(.ROW_W(ROW_W), .KEY_LO(KEY_LO), .KEY_HI(KEY_HI)) u_chk_order (
    .valid(a_valid), .remapped(a_remap), .row(a_row),
    .reg_lock(reg_lock), .prog_en(prog_en), .syn_lock(syn_bit),
    .key_wr_lock(key_wr_lock), .code(code)
  );

  fpg_fuse_store #(.COL_W(COL_W), .ROW_W(ROW_W), .NSTORE(NSTORE),
                   .SYN_ROW(SYN_ROW), .SYN_COL(SYN_COL)) u_store (
    .clk(clk), .rst(rst),
    .wr_en(req_valid && (code == FPG_OK)),
    .wr_sel(a_sel), .wr_row(a_row), .wr_col(a_col),
    .rd_sel(rd_sel), .rd_row(rd_row), .rd_word(rd_word), .syn_bit(syn_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_pulse <= 1'b0;
      err_pulse  <= 1'b0;
      err_code   <= 3'd0;
    end else begin
      done_pulse <= req_valid;
      err_pulse  <= req_valid && (code != FPG_OK);
      err_code   <= req_valid ? code : 3'd0;
    end
  end
endmodule

// File: rtl/fuse_prog_gate_chk.sv
module fuse_prog_gate_chk #(
  parameter int COL_W  = 5,
  parameter int ROW_W  = 6,
  parameter int ARR_W  = 2,
  parameter int KEY_LO = 24,
  parameter int KEY_HI = 31,
  localparam int ADDR_W = COL_W + ROW_W + ARR_W
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              reg_lock,
  input logic              prog_en,
  input logic              key_wr_lock,
  input logic              done_pulse,
  input logic              err_pulse,
  input logic [2:0]        err_code
);
  logic [ARR_W-1:0] arr;
  logic [ROW_W-1:0] row;
  assign arr = req_addr[COL_W+ROW_W +: ARR_W];
  assign row = req_addr[COL_W +: ROW_W];

  AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> done_pulse); // R8
  AST_NO_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !done_pulse); // R8
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> done_pulse); // R8
  AST_BAD_ARRAY_FIRST: assert property (@(posedge clk) disable iff (rst)
    (req_valid && 32'(arr) == 1) |=> (err_pulse && err_code == 3'd1)); // R2
  AST_LOCK_REJECT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && 32'(arr) != 1 && reg_lock) |=> (err_pulse && err_code == 3'd2)); // R3
  AST_PGM_OFF_REJECT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && 32'(arr) != 1 && !reg_lock && !prog_en) |=> (err_pulse && err_code == 3'd3)); // R4
  AST_KEY_ROWS_REJECT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && arr == '0 && !reg_lock && prog_en && key_wr_lock &&
     32'(row) >= KEY_LO && 32'(row) <= KEY_HI) |=> (err_pulse && err_code == 3'd5)); // R6
  AST_OK_CODE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (done_pulse && !err_pulse) |-> err_code == 3'd0); // R7
endmodule

bind fuse_prog_gate fuse_prog_gate_chk #(.COL_W(COL_W), .ROW_W(ROW_W), .ARR_W(ARR_W),
                                         .KEY_LO(KEY_LO), .KEY_HI(KEY_HI)) u_fpg_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
  .reg_lock(reg_lock), .prog_en(prog_en), .key_wr_lock(key_wr_lock),
  .done_pulse(done_pulse), .err_pulse(err_pulse), .err_code(err_code)
);

// File: tb/fuse_prog_gate_bench.sv
module fuse_prog_gate_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [12:0] req_addr = '0;
  logic        reg_lock = 1'b0, prog_en = 1'b0, key_wr_lock = 1'b0;
  logic [1:0]  rd_sel = '0;
  logic [5:0]  rd_row = '0;
  logic        done_pulse, err_pulse;
  logic [2:0]  err_code;
  logic [31:0] rd_word;
  int total = 0, fails = 0;

  always #2 clk = ~clk;

  fuse_prog_gate u_fuse_prog_gate (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .reg_lock(reg_lock), .prog_en(prog_en), .key_wr_lock(key_wr_lock),
    .rd_sel(rd_sel), .rd_row(rd_row), .done_pulse(done_pulse),
    .err_pulse(err_pulse), .err_code(err_code), .rd_word(rd_word)
  );

  typedef struct packed {
    logic [1:0] arr;
    logic [5:0] row;
    logic [4:0] col;
    logic       lk;
    logic       en;
    logic       kl;
    logic [2:0] code;
  } vec_t;

  localparam vec_t VECS [15] = '{
    '{2'd0, 6'd3,  5'd5,  1'b0, 1'b1, 1'b0, 3'd0},  // R7 plain write
    '{2'd1, 6'd0,  5'd0,  1'b0, 1'b1, 1'b0, 3'd1},  // R2 hole
    '{2'd1, 6'd0,  5'd0,  1'b1, 1'b0, 1'b1, 3'd1},  // R2 before everything
    '{2'd0, 6'd4,  5'd0,  1'b1, 1'b0, 1'b0, 3'd2},  // R3 lock before enable
    '{2'd0, 6'd4,  5'd0,  1'b0, 1'b0, 1'b0, 3'd3},  // R4
    '{2'd0, 6'd24, 5'd0,  1'b0, 1'b1, 1'b1, 3'd5},  // R6 low edge
    '{2'd0, 6'd31, 5'd31, 1'b0, 1'b1, 1'b1, 3'd5},  // R6 high edge
    '{2'd0, 6'd23, 5'd31, 1'b0, 1'b1, 1'b1, 3'd0},  // R6 row 23 free
    '{2'd0, 6'd32, 5'd0,  1'b0, 1'b1, 1'b1, 3'd0},  // R6 row 32 free
    '{2'd2, 6'd24, 5'd0,  1'b0, 1'b1, 1'b1, 3'd0},  // R6 remapped array free
    '{2'd3, 6'd63, 5'd31, 1'b0, 1'b1, 1'b0, 3'd0},  // R1 index 3
    '{2'd0, 6'd21, 5'd30, 1'b0, 1'b1, 1'b0, 3'd0},  // R5 set syndrome lock
    '{2'd2, 6'd0,  5'd0,  1'b0, 1'b1, 1'b0, 3'd4},  // R5 reject
    '{2'd3, 6'd0,  5'd0,  1'b0, 1'b0, 1'b0, 3'd3},  // R4 before R5
    '{2'd0, 6'd0,  5'd1,  1'b0, 1'b1, 1'b0, 3'd0}   // R5 array 0 unaffected
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, got, exp);
    end
  endtask

  task automatic do_req(input logic [1:0] a, input logic [5:0] r, input logic [4:0] c,
                        input logic lk, input logic en, input logic kl, input logic [2:0] code);
    @(negedge clk);
    req_addr = {a, r, c}; reg_lock = lk; prog_en = en; key_wr_lock = kl; req_valid = 1'b1;
    @(posedge clk); #1;
    chk(done_pulse === 1'b1, "R8 done", 32'(done_pulse), 32'd1);
    chk(err_pulse === (code != 3'd0), "R8 err", 32'(err_pulse), 32'(code != 3'd0));
    chk(err_code === code, "R2-order code", 32'(err_code), 32'(code));
    @(negedge clk); req_valid = 1'b0;
    @(posedge clk); #1;
    chk(done_pulse === 1'b0, "R8 single cycle", 32'(done_pulse), 32'd0);
  endtask

  task automatic rd_chk(input logic [1:0] s, input logic [5:0] r, input logic [31:0] exp, input string tag);
    @(negedge clk); rd_sel = s; rd_row = r;
    @(posedge clk); #1;
    chk(rd_word === exp, tag, rd_word, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(done_pulse === 1'b0 && err_pulse === 1'b0, "R10 flags", {30'd0, done_pulse, err_pulse}, 32'd0);
    chk(err_code === 3'd0, "R10 code", 32'(err_code), 32'd0);
    chk(rd_word === 32'd0, "R10 rd_word", rd_word, 32'd0);
    @(negedge clk); rst = 1'b0;

    for (int i = 0; i < 15; i++)
      do_req(VECS[i].arr, VECS[i].row, VECS[i].col, VECS[i].lk, VECS[i].en, VECS[i].kl, VECS[i].code);

    rd_chk(2'd0, 6'd3,  32'h0000_0020, "R7 row3 col5");
    rd_chk(2'd0, 6'd4,  32'h0000_0000, "R9 rejected row4");
    rd_chk(2'd0, 6'd24, 32'h0000_0000, "R9 key row24 untouched");
    rd_chk(2'd0, 6'd31, 32'h0000_0000, "R9 key row31 untouched");
    rd_chk(2'd0, 6'd23, 32'h8000_0000, "R6 row23 written");
    rd_chk(2'd0, 6'd32, 32'h0000_0001, "R6 row32 written");
    rd_chk(2'd1, 6'd24, 32'h0000_0001, "R1 index2 to store1");
    rd_chk(2'd2, 6'd63, 32'h8000_0000, "R1 index3 to store2");
    rd_chk(2'd1, 6'd0,  32'h0000_0000, "R9 syndrome blocked store1");
    rd_chk(2'd2, 6'd0,  32'h0000_0000, "R9 blocked store2");
    rd_chk(2'd0, 6'd0,  32'h0000_0002, "R5 array0 row0 col1");
    rd_chk(2'd3, 6'd3,  32'h0000_0000, "R11 sel3 reads zero");

    do_req(2'd0, 6'd3, 5'd7, 1'b0, 1'b1, 1'b0, 3'd0);
    rd_chk(2'd0, 6'd3, 32'h0000_00A0, "R7 bits accumulate");
    do_req(2'd0, 6'd3, 5'd5, 1'b0, 1'b1, 1'b0, 3'd0);
    rd_chk(2'd0, 6'd3, 32'h0000_00A0, "R7 reprogram same bit");
    rd_chk(2'd0, 6'd21, 32'h4000_0000, "R11 syndrome row");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule